// File: doc/BRIEF.md
# Status Register and Write Guard for a Serial EEPROM

This block keeps the status byte of a serial EEPROM and decides, at the moment a write is committed, whether that write may go ahead. The serial front end does the shifting. It reports decoded events to this block as one-cycle pulses: enable-latch set, enable-latch clear, status-write commit with its data byte, array-write commit with its start address, and internal-write completion. The write timer supplies a busy level, and the hardware protect pin is sampled directly.

The block returns the byte that a status read shifts out, plus two combinational permits. One says an array write committed now would be performed. The other says the same for a status write. An accepted status write is held pending and applied only when the internal write finishes, so the pin or the latch changing during the write cannot cancel it. Array protection is decided by the two most significant address bits of the write's start address, because a whole page lies in one protection region.

Top module: `eeprom_wguard`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the status byte reads 0x00 when busy is low, and both permits are low.
- R2: A set pulse makes the enable latch (status bit 1) read 1 from the next cycle. A clear pulse or a write-done pulse makes it read 0 from the next cycle, and clearing wins over a set pulse in the same cycle.
- R3: Status byte layout: bit 7 is the pin-protect enable, bits 6..4 read 0, bits 3..2 are the region-protect code, bit 1 is the enable latch, and bit 0 equals the busy input in the same cycle.
- R4: The array permit is 1 exactly when the latch is 1, busy is 0 and the address lies outside the locked region. Code 00 locks nothing, 01 locks the top quarter (top two address bits 11), 10 locks the top half (top address bit 1), and 11 locks everything.
- R5: The status permit is 1 exactly when the latch is 1, busy is 0, and it is not the case that the pin-protect enable is 1 while the pin is low.
- R6: A status write accepted while the permit is high takes data bit 7 as the new pin-protect enable and data bits 3..2 as the new region code. The new values read back from the cycle after the next write-done pulse and not before.
- R7: Once a status write is accepted, the pin going low or the latch being cleared before write-done does not stop the new values from being applied.
- R8: A status commit made while the permit is low changes neither the stored bits nor the latch, even after a later write-done pulse.
- R9: A commit in the same cycle as a set pulse is judged against the latch value from before that cycle, so it is refused when the latch was 0.
- R10: The protect pin has no effect on the array permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_pin | input | 1 | Hardware protect pin level, 0 = low |
| wren_ev | input | 1 | Pulse: set the enable latch |
| wrdi_ev | input | 1 | Pulse: clear the enable latch |
| sr_cmt_ev | input | 1 | Pulse: status write committed |
| sr_data | input | 8 | Data byte of the status write |
| arr_cmt_ev | input | 1 | Pulse: array write committed |
| arr_addr | input | ADDR_W | Start address of the array write |
| wr_done_ev | input | 1 | Pulse: internal write finished |
| busy | input | 1 | Internal write in progress |
| status_o | output | 8 | Status byte for reads |
| arr_ok_o | output | 1 | Array write would be performed |
| sr_ok_o | output | 1 | Status write would be performed |

## Verification
The bench builds the block with ADDR_W = 11, so the array holds 2048 bytes. The quarter boundary falls at 0x600 and the half boundary at 0x400. Directed steps probe the addresses on either side of both boundaries and at both ends of the array under every region code. Random stimulus then crosses the pin level, the busy flag and same-cycle event collisions against a bench model of the latch and the pending status data.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef struct packed {
    logic       pin_en;
    logic [1:0] region;
  } nv_bits_t;

  function automatic logic region_locked(input logic [1:0] region,
                                         input logic [1:0] top2);
    logic hit;
    case (region)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (top2 == 2'b11);
      2'b10:   hit = top2[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

  function automatic nv_bits_t nv_from_byte(input logic [7:0] d);
    nv_bits_t n;
    n.pin_en = d[7];
    n.region = d[3:2];
    return n;
  endfunction

  function automatic logic [7:0] pack_status(input nv_bits_t n,
                                             input logic latch,
                                             input logic wip);
    return {n.pin_en, 3'b000, n.region, latch, wip};
  endfunction

endpackage

// File: rtl/wel_latch.sv
module wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/prot_decode.sv
module prot_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        region_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  import guard_pkg::*;
  logic [1:0] top2;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top2 = addr_i[ADDR_W-1 -: 2];
    end else begin : g_narrow
      assign top2 = {addr_i[0], addr_i[0]};
    end
  endgenerate

  always_comb locked_o = region_locked(region_i, top2);
endmodule

// File: rtl/nv_status.sv
module nv_status (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept_i,
  input  logic [7:0]          data_i,
  input  logic                done_i,
  output guard_pkg::nv_bits_t nv_o,
  output logic                pend_o
);
  import guard_pkg::*;
  nv_bits_t pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_o   <= '0;
      pend_q <= '0;
      pend_o <= 1'b0;
    end else begin
      if (done_i && pend_o) nv_o <= pend_q;
      if (accept_i) begin
        pend_q <= nv_from_byte(data_i);
        pend_o <= 1'b1;
      end else if (done_i) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eeprom_wguard.sv
module eeprom_wguard #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              wren_ev,
  input  logic              wrdi_ev,
  input  logic              sr_cmt_ev,
  input  logic [7:0]        sr_data,
  input  logic              arr_cmt_ev,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wr_done_ev,
  input  logic              busy,
  output logic [7:0]        status_o,
  output logic              arr_ok_o,
  output logic              sr_ok_o
);
  import guard_pkg::*;

  logic     wel;
  logic     wel_clear;
  logic     locked;
  logic     hw_block;
  logic     sr_accept;
  logic     arr_accept;
  logic     sr_pend;
  nv_bits_t nv;

  assign wel_clear = wrdi_ev | wr_done_ev;

  wel_latch u_wel (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(wren_ev),
    .clr_i(wel_clear),
    .wel_o(wel)
  );

  prot_decode #(.ADDR_W(ADDR_W)) u_prot (
    .region_i(nv.region),
    .addr_i  (arr_addr),
    .locked_o(locked)
  );

  assign hw_block   = nv.pin_en & ~wp_pin;
  assign sr_ok_o    = wel & ~busy & ~hw_block;
  assign arr_ok_o   = wel & ~busy & ~locked;
  assign sr_accept  = sr_cmt_ev & sr_ok_o;
  assign arr_accept = arr_cmt_ev & arr_ok_o;

  nv_status u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept_i(sr_accept),
    .data_i  (sr_data),
    .done_i  (wr_done_ev),
    .nv_o    (nv),
    .pend_o  (sr_pend)
  );

  assign status_o = pack_status(nv, wel, busy);
endmodule

// File: rtl/eeprom_wguard_chk.sv
module eeprom_wguard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_pin,
  input logic       wren_ev,
  input logic       wrdi_ev,
  input logic       wr_done_ev,
  input logic       busy,
  input logic [7:0] status_o,
  input logic       arr_ok_o,
  input logic       sr_ok_o,
  input logic       sr_pend
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (status_o[7:1] == 7'd0 && !arr_ok_o && !sr_ok_o));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);

  assert_wip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] == busy);

  assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_ev && !wrdi_ev && !wr_done_ev) |=> status_o[1]);

  assert_wel_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrdi_ev || wr_done_ev) |=> !status_o[1]);

  assert_arr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_ok_o |-> (status_o[1] && !busy));

  assert_sr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_ok_o |-> (status_o[1] && !(status_o[7] && !wp_pin)));

  assert_nv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done_ev && sr_pend) |=> $stable(status_o[7:2]));
endmodule

bind eeprom_wguard eeprom_wguard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_pin    (wp_pin),
  .wren_ev   (wren_ev),
  .wrdi_ev   (wrdi_ev),
  .wr_done_ev(wr_done_ev),
  .busy      (busy),
  .status_o  (status_o),
  .arr_ok_o  (arr_ok_o),
  .sr_ok_o   (sr_ok_o),
  .sr_pend   (sr_pend)
);

// File: tb/eeprom_wguard_tb.sv
module eeprom_wguard_tb;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wp_pin, wren_ev, wrdi_ev, sr_cmt_ev, arr_cmt_ev, wr_done_ev, busy;
  logic [7:0]    sr_data;
  logic [AW-1:0] arr_addr;
  logic [7:0]    status_o;
  logic          arr_ok_o, sr_ok_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic       m_wel, m_pin_en, m_pend, m_p_pin_en;
  logic [1:0] m_region, m_p_region;

  always #10 clk = ~clk;

  eeprom_wguard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .wren_ev(wren_ev),
    .wrdi_ev(wrdi_ev), .sr_cmt_ev(sr_cmt_ev), .sr_data(sr_data),
    .arr_cmt_ev(arr_cmt_ev), .arr_addr(arr_addr), .wr_done_ev(wr_done_ev),
    .busy(busy), .status_o(status_o), .arr_ok_o(arr_ok_o), .sr_ok_o(sr_ok_o)
  );

  function automatic bit exp_locked(input logic [1:0] r, input int a);
    if (r == 2'd1) return a >= DEPTH - DEPTH / 4;
    if (r == 2'd2) return a >= DEPTH / 2;
    return r == 2'd3;
  endfunction

  function automatic logic [7:0] exp_status();
    logic [7:0] s = 8'h00;
    s[7]   = m_pin_en;
    s[3:2] = m_region;
    s[1]   = m_wel;
    s[0]   = busy;
    return s;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wren_ev = 0; wrdi_ev = 0; sr_cmt_ev = 0; arr_cmt_ev = 0; wr_done_ev = 0;
    busy = 0; sr_data = 8'h00; arr_addr = '0;
  endtask

  // Inputs already driven after a falling edge; checks the combinational
  // permits and the status byte, then advances one clock and updates the model.
  task automatic step(input string tag);
    bit accept;
    #1;
    check({tag, " R3 status"}, status_o, exp_status());
    check({tag, " R4 arr_ok"}, {7'd0, arr_ok_o},
          {7'd0, m_wel & ~busy & ~exp_locked(m_region, int'(arr_addr))});
    check({tag, " R5 sr_ok"}, {7'd0, sr_ok_o},
          {7'd0, m_wel & ~busy & ~(m_pin_en & ~wp_pin)});
    accept = sr_cmt_ev && m_wel && !busy && !(m_pin_en && !wp_pin);
    @(posedge clk);
    if (wr_done_ev && m_pend) begin
      m_pin_en = m_p_pin_en;
      m_region = m_p_region;
    end
    if (accept) begin
      m_pend = 1; m_p_pin_en = sr_data[7]; m_p_region = sr_data[3:2];
    end else if (wr_done_ev) m_pend = 0;
    if (wrdi_ev || wr_done_ev) m_wel = 0;
    else if (wren_ev) m_wel = 1;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; wp_pin = 1; idle_inputs();
    m_wel = 0; m_pin_en = 0; m_region = 0; m_pend = 0; m_p_pin_en = 0; m_p_region = 0;
    repeat (3) @(negedge clk);
    check("R1 status in reset", status_o, 8'h00);
    check("R1 permits in reset", {6'd0, arr_ok_o, sr_ok_o}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 status after reset", status_o, 8'h00);

    // R9: commit in the same cycle as a set pulse sees the old latch
    wren_ev = 1; sr_cmt_ev = 1; sr_data = 8'h8C; step("R9 same cycle");
    wr_done_ev = 1; step("R9 done");
    check("R9 bits unchanged", status_o & 8'h8C, 8'h00);

    // R2: set then set+clear collision
    wren_ev = 1; step("R2 set");
    check("R2 latch set", {7'd0, status_o[1]}, 8'd1);
    wren_ev = 1; wrdi_ev = 1; step("R2 collide");
    check("R2 clear wins", {7'd0, status_o[1]}, 8'd0);

    // R6/R7: accept pin-enable + half region, then pin low and latch clear
    wren_ev = 1; step("R6 set");
    sr_cmt_ev = 1; sr_data = 8'h88; step("R6 commit");
    check("R6 not yet applied", status_o & 8'h8C, 8'h00);
    wp_pin = 0; wrdi_ev = 1; busy = 1; step("R7 pin low");
    wr_done_ev = 1; step("R7 done");
    check("R7 applied despite pin", status_o & 8'h8E, 8'h88);

    // R10 and R4 boundary at half, pin low
    wren_ev = 1; step("R10 set");
    arr_cmt_ev = 1; arr_addr = 11'h3FF; step("R10 below half");
    arr_cmt_ev = 1; arr_addr = 11'h400; step("R4 at half");
    // R8: status commit refused while pin protect holds
    sr_cmt_ev = 1; sr_data = 8'h04; step("R8 refused");
    wr_done_ev = 1; step("R8 done");
    check("R8 bits kept", status_o & 8'h8C, 8'h88);

    // release pin, program quarter region, probe its edges
    wp_pin = 1; wren_ev = 1; step("R4 set");
    sr_cmt_ev = 1; sr_data = 8'h04; step("R4 commit quarter");
    wr_done_ev = 1; step("R4 done");
    check("R6 quarter applied", status_o & 8'h8C, 8'h04);
    wren_ev = 1; step("R4 set2");
    arr_addr = 11'h5FF; step("R4 below quarter");
    arr_addr = 11'h600; step("R4 at quarter");
    arr_addr = 11'h7FF; step("R4 top");
    arr_addr = 11'h000; step("R4 bottom");

    for (int i = 0; i < 3000; i++) begin
      wp_pin     = ($urandom % 4) != 0;
      wren_ev    = ($urandom % 4) == 0;
      wrdi_ev    = ($urandom % 10) == 0;
      sr_cmt_ev  = ($urandom % 5) == 0;
      sr_data    = 8'($urandom);
      arr_cmt_ev = ($urandom % 3) == 0;
      arr_addr   = AW'($urandom);
      wr_done_ev = ($urandom % 6) == 0;
      busy       = ($urandom % 5) == 0;
      step("random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule